// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address used inside a synchronous burst memory. A burst begins when either of two start strobes is high at a rising clock edge: one strobe serves the processor side, the other the memory controller side. Either one captures the external address. From then on, the two least significant address bits are produced internally. They step forward one beat for every cycle in which the advance input is high. The upper address bits stay frozen until the next load.

A four-beat burst always stays inside the aligned group of four words that contains the start address. An order input picks how the two low bits walk: linear order counts upward modulo four from the start offset, and interleaved order XORs the start offset with the beat number. The beat counter wraps after the fourth beat and keeps going. When advance is low the burst pauses. Bursting is optional, because a strobe on every cycle loads a fresh address each cycle with no dead cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first load, addr_o and beat_o are zero.
- R2: When strb_cpu_i or strb_ctl_i (or both) is high at a rising edge, addr_o equals the sampled addr_i after that edge and beat_o is 0.
- R3: When neither strobe is high and adv_i is high at a rising edge, beat_o increments by one modulo 4.
- R4: With order_i = 0 (linear), addr_o[1:0] equals (start offset + beat_o) modulo 4, where the start offset is bits [1:0] of the loaded address.
- R5: With order_i = 1 (interleaved), addr_o[1:0] equals the start offset XOR beat_o.
- R6: addr_o above bit 1 changes only at an edge where a strobe is high.
- R7: When a strobe and adv_i are both high at the same edge, the load takes effect and beat_o is 0 after the edge.
- R8: When no strobe and adv_i is low at an edge, beat_o keeps its value.
- R9: Strobes on consecutive edges load each new address with no lost cycle.
- R10: After beat 3, a further advance returns beat_o to 0 and the address to the start offset, and the burst keeps going.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strb_cpu_i | input | 1 | Processor-side start strobe |
| strb_ctl_i | input | 1 | Controller-side start strobe |
| adv_i | input | 1 | Advance the burst by one beat |
| order_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current internal word address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
A load and an advance can be requested at the same edge. Which one wins decides the next beat and the next address. The bench provokes this with directed cycles that raise each strobe, and both strobes together, while adv_i is also high. It also drives long random stretches where the two inputs often coincide. A behavioural model gives the load priority, and on every clock the bench compares both outputs against that model, so if the advance were allowed to win, beat_o would show 1 instead of 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end

  assert_load_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));
  assert_base_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;   // load outranks advance
    else if (adv_i)  beat_o <= beat_o + 1'b1;
  end

  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> beat_o == BEAT_W'($past(beat_o) + 1));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] offs_o
);
  logic [BEAT_W-1:0] lin_offs;
  logic [BEAT_W-1:0] ilv_offs;

  assign lin_offs = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_offs[b] = start_i[b] ^ beat_i[b];
  end

  assign offs_o = (order_i == ORD_INTERLEAVE) ? ilv_offs : lin_offs;

  always_comb begin
    if (order_i == ORD_LINEAR)
      assert_linear_R4: assert (BEAT_W'(offs_o - start_i) == beat_i);
    else
      assert_interleave_R5: assert ((offs_o ^ start_i) == beat_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_cpu_i,
  input  logic              strb_ctl_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] offs;

  assign load = strb_cpu_i | strb_ctl_i;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .base_o (base)
  );

  burst_beat_cnt u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv_i),
    .beat_o (beat_o)
  );

  burst_order_map u_map (
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat_o),
    .order_i (burst_order_e'(order_i)),
    .offs_o  (offs)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], offs};

  assert_port_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W])) && (beat_o == '0));
  assert_upper_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  assert_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_i && beat_o == 2'd3) |=> beat_o == 2'd0);
  initial assert (HI_W >= 1);
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 18;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_cpu = 1'b0, s_ctl = 1'b0, adv = 1'b0, ord = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [AW-1:0] a_out;
  logic [1:0] b_out;

  int checks = 0, errors = 0;
  int m_base = 0, m_beat = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strb_cpu_i(s_cpu), .strb_ctl_i(s_ctl),
    .adv_i(adv), .order_i(ord), .addr_i(a_in), .addr_o(a_out), .beat_o(b_out));

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int exp_addr();
    int lo;
    lo = ord ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
    return (m_base & ~3) | lo;
  endfunction

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(bit c, bit k, bit v, bit o, int a);
    bit ld;
    s_cpu = c; s_ctl = k; adv = v; ord = o; a_in = AW'(a);
    @(posedge clk);
    ld = c | k;
    if (ld) begin
      tag = v ? "R7" : ((tag == "R2" || tag == "R7" || tag == "R9") ? "R9" : "R2");
      m_base = a; m_beat = 0;
    end else if (v) begin
      tag = (m_beat == 3) ? "R10" : "R3";
      m_beat = (m_beat + 1) % 4;
    end else tag = "R8";
    @(negedge clk);
    check({tag, "/beat"}, b_out, m_beat);
    check({tag, ord ? "/R5" : "/R4", "/addr"}, a_out, exp_addr());
    check({tag, "/R6/upper"}, a_out >> 2, m_base >> 2);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 addr in reset", a_out, 0);
    check("R1 beat in reset", b_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after reset", a_out, 0);
    // linear burst from offset 1 via cpu strobe
    cycle(1, 0, 0, 0, 'h12345);
    for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    // interleaved burst from offset 1 via ctl strobe
    cycle(0, 1, 0, 1, 'h2abc5);
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 1, 0);
    // load with advance, each strobe and both
    cycle(1, 0, 1, 0, 'h00fff);
    cycle(0, 1, 1, 1, 'h30002);
    cycle(1, 1, 1, 0, 'h1fffe);
    // back-to-back loads
    for (int i = 0; i < 6; i++) cycle(i % 2, 1 - i % 2, 0, i % 3 == 0, 'h100 * i + i);
    // random mix
    for (int i = 0; i < 800; i++) begin
      int r;
      r = $urandom;
      cycle(r[0] & r[1], r[2] & r[3] & r[4], r[5] | r[6], r[7], int'($urandom) & 'h3ffff);
    end
    finish_run();
  end
endmodule